// File: doc/BRIEF.md
# Backup Battery Switchover Controller

This controller decides which source feeds a protected output rail. The rail can take power from the main supply or from a backup battery. It also drives an active-low power-fail warning. Its inputs are level flags from external analog comparators:

- the supply is below the switch threshold;
- the battery is higher than the supply;
- the supply is above the reset threshold;
- the monitored power-fail input is below its reference.

It also receives a status bit from the reset generator that says the reset timeout is running.

Every flag passes through a two-flop synchronizer. It then passes through a stability qualifier: a new level must hold for `STABLE_CYCLES` consecutive cycles before the controller sees it. The controller moves to battery mode only when the supply is below the switch threshold and the battery is higher than the supply. It moves back to the main supply only when the supply is above the reset threshold and the reset timeout has started. Both switch selects are turned off for one cycle between modes, so the two sources are never joined.

The state machine has five states:

- `ST_INIT`: power-on. The main switch is selected and the warning is held low.
- `ST_MAIN`: the rail is fed from the main supply.
- `ST_GAP_TO_BATT`: both switches are off, on the way to battery mode.
- `ST_BATT`: the rail is fed from the battery.
- `ST_GAP_TO_MAIN`: both switches are off, on the way back to the main supply.

The transitions are:

- INIT to MAIN: the start-up count ends after `SYNC_STAGES + STABLE_CYCLES + 2` cycles.
- MAIN to GAP_TO_BATT: the supply is below the switch threshold and the battery is higher than the supply.
- GAP_TO_BATT to BATT: taken unconditionally on the next cycle.
- BATT to GAP_TO_MAIN: the supply is above the reset threshold and the reset stretch is active.
- GAP_TO_MAIN to MAIN: taken unconditionally on the next cycle.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: After reset, `main_sel_o`=1, `batt_sel_o`=0 and `pf_n_o`=0 for the start-up window of `SYNC_STAGES+STABLE_CYCLES+2` cycles. The warning output then follows the flags.
- R2: A flag level that lasts fewer than `STABLE_CYCLES` consecutive cycles has no effect on any output.
- R3: The rail leaves the main supply only when both hold: the qualified below-switch-threshold flag is 1, and the qualified battery-higher flag is 1.
- R4: When the supply is below the switch threshold but the battery is not higher than the supply, the rail stays on the main supply (`main_sel_o`=1, `batt_sel_o`=0).
- R5: While the supply is above the switch threshold, toggling the battery-higher flag never leaves main-supply mode.
- R6: Battery mode ends only when the qualified above-reset-threshold flag is 1 and `rst_stretch_i` is 1. Rising above the switch threshold alone keeps the battery selected.
- R7: `main_sel_o` and `batt_sel_o` are never 1 together. At least one cycle with both at 0 separates every change of mode.
- R8: `pf_n_o` is 0 while the qualified power-fail-input-low flag is 1.
- R9: `pf_n_o` is 0 while the qualified below-switch-threshold flag is 1, whatever the power-fail input shows.
- R10: After start-up, `pf_n_o` is 1 when neither the power-fail-input-low flag nor the below-switch-threshold flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vmain_below_sw_i | input | 1 | Comparator flag: supply below the switch threshold |
| batt_above_main_i | input | 1 | Comparator flag: battery higher than the supply |
| vmain_above_rst_i | input | 1 | Comparator flag: supply above the reset threshold |
| pfin_low_i | input | 1 | Comparator flag: power-fail input below its reference |
| rst_stretch_i | input | 1 | Reset generator reports its timeout is running |
| main_sel_o | output | 1 | Enable for the main-supply switch |
| batt_sel_o | output | 1 | Enable for the battery switch |
| pf_n_o | output | 1 | Active-low power-fail warning |

## Verification
The qualified below-switch-threshold flag does two jobs in a single cycle:

- it forces the warning output low;
- together with the battery flag, it starts the break-before-make gap toward battery mode.

The bench provokes this by raising the battery flag while the supply flag is already held low. It then watches every cycle of the switchover. In each cycle it checks that the sources never overlap, that a gap cycle occurs, and that `pf_n_o` is already low during that gap.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_MAIN,
        ST_GAP_TO_BATT,
        ST_BATT,
        ST_GAP_TO_MAIN
    } bsw_state_e;

    localparam int N_FLAGS     = 4;
    localparam int FL_BELOW_SW = 0;
    localparam int FL_BATT_GT  = 1;
    localparam int FL_ABOVE_RST = 2;
    localparam int FL_PFI_LOW  = 3;
endpackage

// File: rtl/bsw_flag_qual.sv
module bsw_flag_qual #(
    parameter int N_FLAGS       = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] raw_i,
    output logic [N_FLAGS-1:0] qual_o
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        logic [SYNC_STAGES-1:0] chain;
        logic [CNT_W-1:0]       cnt;
        logic                   held;
        logic                   synced;

        assign synced    = chain[SYNC_STAGES-1];
        assign qual_o[g] = held;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                cnt   <= '0;
                held  <= 1'b0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], raw_i[g]};
                if (synced != held) begin
                    if (cnt == CNT_W'(STABLE_CYCLES - 1)) begin
                        held <= synced;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bsw_fsm.sv
module bsw_fsm
    import bsw_pkg::*;
#(
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_sw,
    input  logic batt_gt,
    input  logic above_rst,
    input  logic pfi_low,
    input  logic stretch,
    output logic main_sel,
    output logic batt_sel,
    output logic pf_n
);
    localparam int IW = $clog2(INIT_CYCLES + 1);

    bsw_state_e state_q, state_d;
    logic [IW-1:0] init_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_INIT;
            init_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) init_cnt <= init_cnt + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:        if (init_cnt == IW'(INIT_CYCLES - 1)) state_d = ST_MAIN;
            ST_MAIN:        if (below_sw && batt_gt) state_d = ST_GAP_TO_BATT;
            ST_GAP_TO_BATT: state_d = ST_BATT;
            ST_BATT:        if (above_rst && stretch) state_d = ST_GAP_TO_MAIN;
            ST_GAP_TO_MAIN: state_d = ST_MAIN;
            default:        state_d = ST_INIT;
        endcase
    end

    always_comb begin
        main_sel = 1'b0;
        batt_sel = 1'b0;
        pf_n     = !(pfi_low || below_sw);
        unique case (state_q)
            ST_INIT: begin
                main_sel = 1'b1;
                pf_n     = 1'b0;
            end
            ST_MAIN:        main_sel = 1'b1;
            ST_BATT:        batt_sel = 1'b1;
            ST_GAP_TO_BATT,
            ST_GAP_TO_MAIN: ;
            default: begin
                main_sel = 1'b1;
                pf_n     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
    import bsw_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vmain_below_sw_i,
    input  logic batt_above_main_i,
    input  logic vmain_above_rst_i,
    input  logic pfin_low_i,
    input  logic rst_stretch_i,
    output logic main_sel_o,
    output logic batt_sel_o,
    output logic pf_n_o
);
    localparam int INIT_CYCLES = SYNC_STAGES + STABLE_CYCLES + 2;

    logic [N_FLAGS-1:0] raw_flags;
    logic [N_FLAGS-1:0] qual_flags;
    logic below_q, battgt_q, aboverst_q, pfilow_q;

    always_comb begin
        raw_flags               = '0;
        raw_flags[FL_BELOW_SW]  = vmain_below_sw_i;
        raw_flags[FL_BATT_GT]   = batt_above_main_i;
        raw_flags[FL_ABOVE_RST] = vmain_above_rst_i;
        raw_flags[FL_PFI_LOW]   = pfin_low_i;
    end

    bsw_flag_qual #(
        .N_FLAGS      (N_FLAGS),
        .SYNC_STAGES  (SYNC_STAGES),
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_flags),
        .qual_o(qual_flags)
    );

    assign below_q    = qual_flags[FL_BELOW_SW];
    assign battgt_q   = qual_flags[FL_BATT_GT];
    assign aboverst_q = qual_flags[FL_ABOVE_RST];
    assign pfilow_q   = qual_flags[FL_PFI_LOW];

    bsw_fsm #(
        .INIT_CYCLES(INIT_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .below_sw (below_q),
        .batt_gt  (battgt_q),
        .above_rst(aboverst_q),
        .pfi_low  (pfilow_q),
        .stretch  (rst_stretch_i),
        .main_sel (main_sel_o),
        .batt_sel (batt_sel_o),
        .pf_n     (pf_n_o)
    );
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker (
    input logic clk,
    input logic rst_n,
    input logic below_f,
    input logic battgt_f,
    input logic aboverst_f,
    input logic pfilow_f,
    input logic stretch_i,
    input logic main_sel,
    input logic batt_sel,
    input logic pf_n
);
    AST_NEVER_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_sel && batt_sel)); // R7

    AST_GAP_BEFORE_BATT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_sel) |-> $past(!main_sel)); // R7

    AST_GAP_BEFORE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_sel) |-> $past(!batt_sel)); // R7

    AST_BATT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_sel) |-> $past(below_f && battgt_f, 2)); // R3

    AST_RETURN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batt_sel) |-> $past(aboverst_f && stretch_i)); // R6

    AST_PF_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        below_f |-> !pf_n); // R9

    AST_PF_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pfilow_f |-> !pf_n); // R8
endmodule

bind bkup_switch_ctrl bsw_checker u_bsw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .below_f   (below_q),
    .battgt_f  (battgt_q),
    .aboverst_f(aboverst_q),
    .pfilow_f  (pfilow_q),
    .stretch_i (rst_stretch_i),
    .main_sel  (main_sel_o),
    .batt_sel  (batt_sel_o),
    .pf_n      (pf_n_o)
);

// File: tb/tb_bkup_switch_ctrl.sv
`timescale 1ns/1ps
module tb_bkup_switch_ctrl;
    localparam int SYNC_STAGES   = 2;
    localparam int STABLE_CYCLES = 4;
    localparam int INIT_CYCLES   = SYNC_STAGES + STABLE_CYCLES + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below = 1'b0, battgt = 1'b0, aboverst = 1'b0, pfilow = 1'b0, stretch = 1'b0;
    logic main_sel, batt_sel, pf_n;
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bkup_switch_ctrl #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYCLES(STABLE_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n),
        .vmain_below_sw_i(below), .batt_above_main_i(battgt),
        .vmain_above_rst_i(aboverst), .pfin_low_i(pfilow),
        .rst_stretch_i(stretch),
        .main_sel_o(main_sel), .batt_sel_o(batt_sel), .pf_n_o(pf_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_main(input string req);
        check(req, "main_sel", int'(main_sel), 1);
        check(req, "batt_sel", int'(batt_sel), 0);
    endtask

    // Watch a switchover cycle by cycle: no overlap, a gap, and final mode.
    task automatic watch_switch(input string req, input bit to_batt, input bit pf_low_in_gap);
        int overlap = 0;
        int gap = 0;
        int gap_pf_bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (main_sel && batt_sel) overlap++;
            if (!main_sel && !batt_sel) begin
                gap++;
                if (pf_low_in_gap && pf_n) gap_pf_bad++;
            end
        end
        check(req, "overlap cycles", overlap, 0);
        check(req, "gap seen", int'(gap >= 1), 1);
        if (pf_low_in_gap) check("R9", "pf_n high during gap", gap_pf_bad, 0);
        check(req, "final batt_sel", int'(batt_sel), int'(to_batt));
        check(req, "final main_sel", int'(main_sel), int'(!to_batt));
    endtask

    task automatic t_reset;
        int bad = 0;
        rst_n = 1'b0;
        wait_cycles(3);
        rst_n = 1'b1;
        for (int i = 0; i < INIT_CYCLES - 2; i++) begin
            @(negedge clk);
            if (!main_sel || batt_sel || pf_n) bad++;
        end
        check("R1", "startup window violations", bad, 0);
        wait_cycles(10);
        check_main("R1");
        check("R10", "pf_n idle", int'(pf_n), 1);
    endtask

    task automatic t_pfi;
        pfilow = 1'b1;
        wait_cycles(12);
        check("R8", "pf_n with pfi low", int'(pf_n), 0);
        pfilow = 1'b0;
        wait_cycles(12);
        check("R10", "pf_n released", int'(pf_n), 1);
    endtask

    task automatic t_glitch;
        int dropped = 0;
        pfilow = 1'b1;
        wait_cycles(STABLE_CYCLES - 2);
        pfilow = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (!pf_n) dropped++;
        end
        check("R2", "pf_n drop on short pulse", dropped, 0);
        below = 1'b1; battgt = 1'b1;
        wait_cycles(STABLE_CYCLES - 2);
        below = 1'b0; battgt = 1'b0;
        dropped = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (!main_sel || batt_sel) dropped++;
        end
        check("R2", "mode change on short pulse", dropped, 0);
    endtask

    task automatic t_batt_loss;
        int bad = 0;
        aboverst = 1'b1;
        for (int k = 0; k < 6; k++) begin
            battgt = ~battgt;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!main_sel || batt_sel) bad++;
            end
        end
        battgt = 1'b0;
        check("R5", "left main on battery toggling", bad, 0);
    endtask

    task automatic t_low_batt;
        aboverst = 1'b0;
        below = 1'b1;
        battgt = 1'b0;
        wait_cycles(15);
        check_main("R4");
        check("R9", "pf_n with supply below switch", int'(pf_n), 0);
    endtask

    task automatic t_enter;
        battgt = 1'b1;
        watch_switch("R3", 1'b1, 1'b1);
    endtask

    task automatic t_return;
        below = 1'b0;
        wait_cycles(15);
        check("R6", "batt kept above switch only", int'(batt_sel), 1);
        aboverst = 1'b1;
        wait_cycles(15);
        check("R6", "batt kept without stretch", int'(batt_sel), 1);
        stretch = 1'b1;
        watch_switch("R7", 1'b0, 1'b0);
        stretch = 1'b0;
        check("R10", "pf_n after return", int'(pf_n), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pfi();
        t_glitch();
        t_batt_loss();
        t_low_batt();
        t_enter();
        t_return();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule